// File: doc/BRIEF.md
# Central Bus Arbiter with Grant Parking

This block arbitrates one shared bus among `N_MASTERS` masters. Each master has a private request line and a private grant line. A master may drive the bus only while its grant is high. It gives the bus back either by pulsing the shared `done_i` line or by dropping its request. The next owner is chosen combinationally during every cycle of the running transfer, so the winner is already known when the owner finishes. The handover then costs only a single fixed turnaround cycle in which no grant is high. No separate arbitration cycle is spent.

When nobody else wants the bus, the grant stays parked on the last owner. That master can start further transfers without any handover. If another master asks while the parked owner is not requesting, the arbiter takes the grant back. The winner is the first requester found by scanning upward and wrapping from a rotating pointer. Each time ownership changes, the pointer moves to just past the new owner, so no requester can be passed over indefinitely.

The controller has three states. PARKED holds the grant with no transfer in progress. OWNED holds the grant while a transfer runs. TURN is the one-cycle gap with no grant.

The transitions are:
- PARKED→OWNED when the holder requests.
- PARKED→TURN when the holder is idle and another master requests.
- PARKED→PARKED otherwise.
- OWNED→OWNED while the owner requests and `done_i` is low.
- OWNED→TURN on release when another master requests.
- OWNED→PARKED on release when no other master requests.
- TURN→OWNED if the new owner still requests.
- TURN→PARKED if it does not.

Top module: `bus_park_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, the grant is parked on master 0 (`gnt_o` equals one-hot bit 0).
- R2: At most one bit of `gnt_o` is high in any cycle.
- R3: While the owner holds its request high and `done_i` is low, its grant does not change, even if other masters request.
- R4: Release happens on the edge where the owner has `done_i` high or its request low. If another master requests at that edge, `gnt_o` is all zero for exactly one cycle and then goes to the chosen winner.
- R5: On release with no other requester, the grant stays on the same master with no gap. A parked master stays granted whatever its own request does, and it resumes without a gap.
- R6: If the parked holder is not requesting at an edge where another master requests, the grant is removed at that edge.
- R7: The winner is the first requesting master, other than the current holder, found by scanning indices upward from the pointer and wrapping from `N_MASTERS-1` to 0. On each ownership change the pointer is set to the new owner's index plus one, wrapping. After reset the pointer is 1.
- R8: If every master requests and each owner releases in turn, ownership visits every other master before returning to a previous one.
- R9: If the chosen winner drops its request during the turnaround cycle, it still receives the grant, parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_MASTERS | Per-master bus request |
| done_i | input | 1 | Owner's end-of-transfer pulse |
| gnt_o | output | N_MASTERS | Per-master grant, at most one high |

## Verification
The hardest case to reach is a winner that withdraws during the turnaround cycle. From the ports it is one cycle wide and only exists after a reclaim or a release with a competitor. The bench first parks the grant on one master. It then raises a single other request and drops that request again at the next falling edge, so that the gap cycle sees no request from the new owner. Round-robin order around the wrap point is reached by keeping every request high and pulsing `done_i` repeatedly from a known pointer position.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ARB_PARKED = 2'd0,
        ARB_OWNED  = 2'd1,
        ARB_TURN   = 2'd2
    } arb_state_e;
endpackage

// File: rtl/arb_pick.sv
// Rotating-priority picker: first set candidate at or after 'start', wrapping.
module arb_pick #(
    parameter int N_MASTERS = 4,
    localparam int PW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] cand,
    input  logic [PW-1:0]        start,
    output logic                 found,
    output logic [PW-1:0]        win
);
    logic [PW:0] idx;

    always_comb begin
        found = 1'b0;
        win   = '0;
        idx   = '0;
        for (int k = 0; k < N_MASTERS; k++) begin
            idx = {1'b0, start} + (PW+1)'(k);
            if (idx >= (PW+1)'(N_MASTERS)) begin
                idx = idx - (PW+1)'(N_MASTERS);
            end
            if (!found && cand[idx[PW-1:0]]) begin
                found = 1'b1;
                win   = idx[PW-1:0];
            end
        end
    end
endmodule

// File: rtl/arb_onehot.sv
// Index-to-one-hot decoder.
module arb_onehot #(
    parameter int N_MASTERS = 4,
    localparam int PW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [PW-1:0]        idx,
    output logic [N_MASTERS-1:0] vec
);
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_dec
        assign vec[g] = (idx == PW'(g));
    end
endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 done_i,
    output logic [N_MASTERS-1:0] gnt_o
);
    localparam int PW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
    localparam logic [PW-1:0] LAST_IDX = PW'(N_MASTERS - 1);

    arb_state_e          state_q, state_d;
    logic [PW-1:0]       owner_q, owner_d;
    logic [PW-1:0]       ptr_q, ptr_d;
    logic [N_MASTERS-1:0] own_oh;
    logic [N_MASTERS-1:0] rivals;
    logic                own_req;
    logic                rival_found;
    logic [PW-1:0]       rival_win;
    logic [PW-1:0]       win_next_ptr;

    arb_onehot #(.N_MASTERS(N_MASTERS)) u_own_dec (
        .idx (owner_q),
        .vec (own_oh)
    );

    assign rivals  = req_i & ~own_oh;
    assign own_req = |(req_i & own_oh);

    // Next-owner search runs every cycle, overlapped with the transfer.
    arb_pick #(.N_MASTERS(N_MASTERS)) u_pick (
        .cand  (rivals),
        .start (ptr_q),
        .found (rival_found),
        .win   (rival_win)
    );

    assign win_next_ptr = (rival_win == LAST_IDX) ? '0 : rival_win + PW'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_PARKED;
            owner_q <= '0;
            ptr_q   <= (N_MASTERS > 1) ? PW'(1) : '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            ptr_q   <= ptr_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ARB_PARKED: begin
                if (own_req) begin
                    state_d = ARB_OWNED;
                end else if (rival_found) begin
                    state_d = ARB_TURN;
                    owner_d = rival_win;
                    ptr_d   = win_next_ptr;
                end
            end
            ARB_OWNED: begin
                if (done_i || !own_req) begin
                    if (rival_found) begin
                        state_d = ARB_TURN;
                        owner_d = rival_win;
                        ptr_d   = win_next_ptr;
                    end else begin
                        state_d = ARB_PARKED;
                    end
                end
            end
            ARB_TURN: begin
                state_d = own_req ? ARB_OWNED : ARB_PARKED;
            end
            default: state_d = ARB_PARKED;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ARB_TURN: gnt_o = '0;
            default:  gnt_o = own_oh;
        endcase
    end

    // Assertions
    p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    p_hold_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_OWNED && (req_i & gnt_o) != '0 && !done_i) |=> $stable(gnt_o));

    p_gap_between_owners_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && $past(gnt_o) != '0) |-> gnt_o == $past(gnt_o));

    p_gap_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0) |=> (gnt_o != '0));

    p_park_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && (req_i & ~gnt_o) == '0) |=> $stable(gnt_o));

    p_reclaim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_PARKED && (req_i & gnt_o) == '0 && (req_i & ~gnt_o) != '0)
        |=> gnt_o == '0);
endmodule

// File: tb/bus_park_arbiter_test.sv
module bus_park_arbiter_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         done = 1'b0;
    logic [N-1:0] gnt;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    bus_park_arbiter #(.N_MASTERS(N)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req),
        .done_i (done),
        .gnt_o  (gnt)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gnt actual %b expected %b", tag, act, exp);
        end
    endtask

    // One clock edge, then land on the falling edge; also checks R2 there.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if ($countones(gnt) > 1) begin
            n_fail++;
            $display("FAIL R2: gnt actual %b expected at most one bit", gnt);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 during reset", gnt, 4'b0001);
        rst_n = 1'b1;
        step();
        chk("R1 after reset", gnt, 4'b0001);
    endtask

    // Parked m0 idle, m2 asks: reclaim, gap, grant m2 (pointer 1 -> first requester 2).
    task automatic t_reclaim();
        req = 4'b0100;
        step();
        chk("R6 reclaim gap", gnt, 4'b0000);
        step();
        chk("R7 winner m2", gnt, 4'b0100);
    endtask

    // Owner m2 keeps bus while m0 also asks.
    task automatic t_hold();
        req = 4'b0101;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R3 hold owner", gnt, 4'b0100);
        end
    endtask

    // done with rival m0: one-cycle gap then m0.
    task automatic t_release_done();
        done = 1'b1;
        step();
        done = 1'b0;
        chk("R4 gap after done", gnt, 4'b0000);
        step();
        chk("R4 handover to m0", gnt, 4'b0001);
    endtask

    // All request; rotation 1,2,3 then wrap to 1 (m0 excluded as owner at that point? no: from ptr 0).
    task automatic t_rotate();
        req = 4'b1110;                  // m0 drops: release, pointer 1 -> m1
        step();
        chk("R4 gap on drop", gnt, 4'b0000);
        step();
        chk("R7 rotate m1", gnt, 4'b0010);
        done = 1'b1; step(); done = 1'b0;
        chk("R8 gap", gnt, 4'b0000);
        step();
        chk("R8 rotate m2", gnt, 4'b0100);
        done = 1'b1; step(); done = 1'b0;
        step();
        chk("R8 rotate m3", gnt, 4'b1000);
        done = 1'b1; step(); done = 1'b0;
        step();
        chk("R7 wrap to m1", gnt, 4'b0010);
    endtask

    // Owner m1 alone: release keeps grant; parked regardless of its request.
    task automatic t_park();
        req = 4'b0010;
        done = 1'b1; step(); done = 1'b0;
        chk("R5 park after done", gnt, 4'b0010);
        req = 4'b0000;
        step();
        chk("R5 park idle", gnt, 4'b0010);
        step();
        chk("R5 park idle 2", gnt, 4'b0010);
        req = 4'b0010;
        step();
        chk("R5 resume no gap", gnt, 4'b0010);
        req = 4'b0000;
        step();
        chk("R5 drop keeps park", gnt, 4'b0010);
    endtask

    // Parked m1, m0 asks then withdraws in the gap: m0 still parked-granted.
    task automatic t_withdraw();
        req = 4'b0001;
        step();
        chk("R6 gap before m0", gnt, 4'b0000);
        req = 4'b0000;
        step();
        chk("R9 parked on m0", gnt, 4'b0001);
        step();
        chk("R9 stays on m0", gnt, 4'b0001);
    endtask

    initial begin
        t_reset();
        t_reclaim();
        t_hold();
        t_release_done();
        t_rotate();
        t_park();
        t_withdraw();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule